// File: doc/BRIEF.md
# Dual Reference Clock Monitor and Switch

This block watches two reference clocks with a free-running system clock, latches a failure flag for each one, and chooses which of the two feeds the reference input of a downstream PLL. A clock counts as failed when its synchronized level does not change for `WINDOW` consecutive system cycles. Failure flags are active low and latched. Once a flag is low, only a clear request brings it back high. The clear request is synchronized and edge-detected. It also reloads the selection from the select input.

There are two selection modes. In manual mode the selection follows the select input, and failures are only reported. In automatic mode the selection is held. When the active clock fails, the block moves the selection to the other clock, but only if that clock is still healthy. Automatic mode needs the PLL-bypass input to be low. With bypass high, the block behaves as in manual mode. A status-valid output follows a synchronized PLL lock input.

Top module: `refmon_switch`

## Requirements
- R1: A reference clock whose synchronized level stays unchanged for `WINDOW` (default 16) system cycles has its alarm output driven low. A clock that toggles at least once every few cycles keeps its alarm high.
- R2: An alarm that is low stays low after its clock resumes toggling, until a clear pulse occurs.
- R3: `alarm_clr_i` passes through a two-flop synchronizer. Each 0-to-1 transition produces exactly one clear pulse, and that pulse drives both alarms high on the third system clock edge. Holding the input high does not clear again, so a clock that fails while the input is held still drops its alarm.
- R4: The clear pulse loads the indicator `sel_ind_o` from `ref_sel_i`, where 0 selects clock 0 and 1 selects clock 1. This happens in every mode.
- R5: In manual mode (`auto_mode_i`=0), `sel_ind_o` equals `ref_sel_i` one edge after it changes. A failure never changes the selection in this mode.
- R6: In automatic mode (`auto_mode_i`=1, `pll_bypass_i`=0), the selection ignores `ref_sel_i`. When the alarm of the active clock is low and the other alarm is high, the selection flips on the next edge and stays there after the failed clock recovers.
- R7: In automatic mode the block never switches to a clock whose alarm is low. When both alarms are low, the selection is kept.
- R8: With `pll_bypass_i`=1, the block behaves as in manual mode whatever the value of `auto_mode_i`.
- R9: `ref_clk_o` carries `ref_clk1_i` when `sel_ind_o` is 1 and `ref_clk0_i` when it is 0.
- R10: `status_valid_o` equals `pll_lock_i` delayed by two system clock edges.
- R11: While `rst_ni` is low, both alarms are high, `sel_ind_o` is 0 and `status_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for monitoring |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk0_i | input | 1 | Reference clock 0 |
| ref_clk1_i | input | 1 | Reference clock 1 |
| ref_sel_i | input | 1 | Primary select (0: clock 0, 1: clock 1) |
| auto_mode_i | input | 1 | 1 selects automatic switching, 0 manual |
| pll_bypass_i | input | 1 | 1 forces manual behaviour |
| alarm_clr_i | input | 1 | Alarm clear request, edge-triggered |
| pll_lock_i | input | 1 | PLL lock indication |
| alarm0_no | output | 1 | Clock 0 failure, active low |
| alarm1_no | output | 1 | Clock 1 failure, active low |
| sel_ind_o | output | 1 | Currently selected reference |
| status_valid_o | output | 1 | Status outputs are valid |
| ref_clk_o | output | 1 | Selected reference clock |

## Verification
The results arrive with fixed delays:
- A select change appears on the indicator after one edge.
- A lock change reaches status-valid after two edges.
- A clear request restores the alarms and reloads the indicator on the third edge.
- A stalled clock drops its alarm about `WINDOW`+3 edges after its last transition.
- In automatic mode, the switch follows one edge after the alarm falls.

A behavioural model in the bench advances these delays on every rising edge. The outputs are compared with it 2 ns after each edge. Inputs change only on falling edges. Directed checks allow several cycles of margin around each delay, so they test the outcome of each scenario and the model tests the exact cycle.

// File: rtl/refmon_pkg.sv
package refmon_pkg;
  typedef enum logic {
    SRC_CLK0 = 1'b0,
    SRC_CLK1 = 1'b1
  } src_e;

  localparam int unsigned NUM_REFS = 2;

  function automatic src_e other_src(src_e s);
    return (s == SRC_CLK0) ? SRC_CLK1 : SRC_CLK0;
  endfunction
endpackage

// File: rtl/refmon_sync.sv
module refmon_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/refmon_watch.sv
module refmon_watch #(
  parameter int unsigned WINDOW = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  input  logic clr_i,
  output logic alarm_no
);
  localparam int unsigned CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WINDOW);

  logic          ref_s;
  logic          ref_d_q;
  logic          toggle;
  logic [CW-1:0] idle_q;
  logic          expired;
  logic          alarm_q;

  refmon_sync #(.WIDTH(1), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ref_i),
    .q_o   (ref_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_d_q <= 1'b0;
    else         ref_d_q <= ref_s;
  end

  assign toggle  = ref_s ^ ref_d_q;
  assign expired = (idle_q == LIMIT);

  // saturating idle age
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idle_q <= '0;
    else if (toggle)  idle_q <= '0;
    else if (!expired) idle_q <= idle_q + 1'b1;
  end

  // latched alarm, clear wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      alarm_q <= 1'b1;
    else if (clr_i)   alarm_q <= 1'b1;
    else if (expired) alarm_q <= 1'b0;
  end

  assign alarm_no = alarm_q;

  a_r2_alarm_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alarm_q && !clr_i) |=> !alarm_q)
    else $error("R2 alarm released without clear");

  a_r3_clear_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> alarm_q)
    else $error("R3 clear did not restore alarm");

  a_r1_no_early_alarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle |=> alarm_q || !$past(alarm_q))
    else $error("R1 alarm fell right after activity");
endmodule

// File: rtl/refmon_select.sv
module refmon_select
  import refmon_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                ref_sel_i,
  input  logic                auto_en_i,
  input  logic [NUM_REFS-1:0] alarm_n_i,
  output logic                sel_o
);
  src_e sel_q;
  src_e sel_d;
  logic act_ok;
  logic oth_ok;

  assign act_ok = alarm_n_i[sel_q];
  assign oth_ok = alarm_n_i[other_src(sel_q)];

  always_comb begin
    sel_d = sel_q;
    if (clr_i) begin
      sel_d = src_e'(ref_sel_i);
    end else if (auto_en_i) begin
      if (!act_ok && oth_ok) sel_d = other_src(sel_q);
    end else begin
      sel_d = src_e'(ref_sel_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= SRC_CLK0;
    else         sel_q <= sel_d;
  end

  assign sel_o = sel_q;

  a_r5_manual_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_en_i && !clr_i) |=> (sel_o == $past(ref_sel_i)))
    else $error("R5 manual selection mismatch");

  a_r4_clear_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sel_o == $past(ref_sel_i)))
    else $error("R4 clear did not load select");

  a_r7_no_switch_to_failed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && !clr_i && !alarm_n_i[other_src(sel_q)]) |=> $stable(sel_o))
    else $error("R7 switched to failed clock");

  a_r6_switch_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && !clr_i && alarm_n_i[sel_q]) |=> $stable(sel_o))
    else $error("R6 switch without failure");
endmodule

// File: rtl/refmon_switch.sv
module refmon_switch
  import refmon_pkg::*;
#(
  parameter int unsigned WINDOW = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_clk0_i,
  input  logic ref_clk1_i,
  input  logic ref_sel_i,
  input  logic auto_mode_i,
  input  logic pll_bypass_i,
  input  logic alarm_clr_i,
  input  logic pll_lock_i,
  output logic alarm0_no,
  output logic alarm1_no,
  output logic sel_ind_o,
  output logic status_valid_o,
  output logic ref_clk_o
);
  logic [NUM_REFS-1:0] ref_vec;
  logic [NUM_REFS-1:0] alarm_n;
  logic                clr_s;
  logic                clr_d_q;
  logic                clr_pulse;
  logic                lock_s;
  logic                sel;
  logic                auto_en;

  assign ref_vec = {ref_clk1_i, ref_clk0_i};

  refmon_sync #(.WIDTH(1), .STAGES(2)) u_clr_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (alarm_clr_i),
    .q_o   (clr_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_d_q <= 1'b0;
    else         clr_d_q <= clr_s;
  end

  assign clr_pulse = clr_s & ~clr_d_q;

  refmon_sync #(.WIDTH(1), .STAGES(2)) u_lock_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pll_lock_i),
    .q_o   (lock_s)
  );

  for (genvar g = 0; g < NUM_REFS; g++) begin : g_watch
    refmon_watch #(.WINDOW(WINDOW)) u_watch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ref_i   (ref_vec[g]),
      .clr_i   (clr_pulse),
      .alarm_no(alarm_n[g])
    );
  end

  assign auto_en = auto_mode_i & ~pll_bypass_i;

  refmon_select u_select (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_pulse),
    .ref_sel_i(ref_sel_i),
    .auto_en_i(auto_en),
    .alarm_n_i(alarm_n),
    .sel_o    (sel)
  );

  assign alarm0_no      = alarm_n[0];
  assign alarm1_no      = alarm_n[1];
  assign sel_ind_o      = sel;
  assign status_valid_o = lock_s;
  assign ref_clk_o      = sel ? ref_clk1_i : ref_clk0_i;

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_pulse |=> !clr_pulse)
    else $error("R3 clear pulse longer than one cycle");

  a_r8_bypass_manual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_bypass_i && !clr_pulse) |=> (sel_ind_o == $past(ref_sel_i)))
    else $error("R8 bypass did not force manual");
endmodule

// File: tb/refmon_switch_test.sv
module refmon_switch_test;
  localparam int unsigned W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ref_clk0 = 1'b0, ref_clk1 = 1'b0;
  logic ref_sel = 1'b0, auto_mode = 1'b0, bypass = 1'b0, clr = 1'b0, lock = 1'b0;
  logic alarm0_n, alarm1_n, sel_ind, valid, ref_out;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string cur_req = "R11";
  bit run0 = 1'b1, run1 = 1'b1;
  int ph0 = 0, ph1 = 0;

  always #5 clk = ~clk;

  refmon_switch #(.WINDOW(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ref_clk0_i(ref_clk0), .ref_clk1_i(ref_clk1),
    .ref_sel_i(ref_sel), .auto_mode_i(auto_mode), .pll_bypass_i(bypass),
    .alarm_clr_i(clr), .pll_lock_i(lock), .alarm0_no(alarm0_n), .alarm1_no(alarm1_n),
    .sel_ind_o(sel_ind), .status_valid_o(valid), .ref_clk_o(ref_out)
  );

  // reference clocks: half periods 3 and 5 system cycles
  always @(negedge clk) begin
    if (run0) begin ph0 = ph0 + 1; if (ph0 == 3) begin ph0 = 0; ref_clk0 <= ~ref_clk0; end end
    if (run1) begin ph1 = ph1 + 1; if (ph1 == 5) begin ph1 = 0; ref_clk1 <= ~ref_clk1; end end
  end

  // behavioural model: sample queues, idle ages, latched flags
  bit   seen0 [$], seen1 [$], clr_seen [$], lock_seen [$];
  int   age0 = 0, age1 = 0;
  bit   m_al0 = 1, m_al1 = 1, m_sel = 0, m_clr_prev = 0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      seen0 = '{0, 0, 0}; seen1 = '{0, 0, 0}; clr_seen = '{0, 0}; lock_seen = '{0, 0};
      age0 = 0; age1 = 0; m_al0 = 1; m_al1 = 1; m_sel = 0; m_clr_prev = 0;
    end else begin
      bit clr_now, act_bad, oth_ok, chg0, chg1, auto_on;
      clr_now = clr_seen[1] && !m_clr_prev;
      chg0 = seen0[1] != seen0[2];
      chg1 = seen1[1] != seen1[2];
      auto_on = auto_mode && !bypass;
      act_bad = m_sel ? !m_al1 : !m_al0;
      oth_ok  = m_sel ? m_al0 : m_al1;
      if (clr_now) m_sel = ref_sel;
      else if (!auto_on) m_sel = ref_sel;
      else if (act_bad && oth_ok) m_sel = !m_sel;
      if (clr_now) m_al0 = 1; else if (age0 >= W) m_al0 = 0;
      if (clr_now) m_al1 = 1; else if (age1 >= W) m_al1 = 0;
      age0 = chg0 ? 0 : (age0 >= W ? W : age0 + 1);
      age1 = chg1 ? 0 : (age1 >= W ? W : age1 + 1);
      m_clr_prev = clr_seen[1];
      void'(seen0.pop_back()); seen0.push_front(ref_clk0);
      void'(seen1.pop_back()); seen1.push_front(ref_clk1);
      void'(clr_seen.pop_back()); clr_seen.push_front(clr);
      void'(lock_seen.pop_back()); lock_seen.push_front(lock);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_ni) begin
      chk(alarm0_n === m_al0, cur_req, "model alarm0", alarm0_n, m_al0);
      chk(alarm1_n === m_al1, cur_req, "model alarm1", alarm1_n, m_al1);
      chk(sel_ind === m_sel, cur_req, "model sel_ind", sel_ind, m_sel);
      chk(valid === lock_seen[1], "R10", "model valid", valid, lock_seen[1]);
      chk(ref_out === (m_sel ? ref_clk1 : ref_clk0), "R9", "model ref_clk", ref_out,
          m_sel ? ref_clk1 : ref_clk0);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    wait_cyc(5);
    @(negedge clk); clr = 1'b0;
    wait_cyc(3);
  endtask

  initial begin
    wait_cyc(4);
    cur_req = "R11";
    chk(alarm0_n === 1'b1, "R11", "reset alarm0", alarm0_n, 1);
    chk(alarm1_n === 1'b1, "R11", "reset alarm1", alarm1_n, 1);
    chk(sel_ind === 1'b0, "R11", "reset sel_ind", sel_ind, 0);
    chk(valid === 1'b0, "R11", "reset valid", valid, 0);
    @(negedge clk); rst_ni = 1'b1;
    wait_cyc(20);
    chk(alarm0_n === 1'b1 && alarm1_n === 1'b1, "R1", "running clocks alarm", alarm0_n, 1);

    // R10 lock path
    @(negedge clk); lock = 1'b1;
    wait_cyc(1);
    chk(valid === 1'b0, "R10", "valid after 1 edge", valid, 0);
    wait_cyc(1);
    chk(valid === 1'b1, "R10", "valid after 2 edges", valid, 1);

    // R5 manual follows select, R9 mux
    cur_req = "R5";
    @(negedge clk); ref_sel = 1'b1;
    wait_cyc(1);
    chk(sel_ind === 1'b1, "R5", "manual sel 1", sel_ind, 1);
    chk(ref_out === ref_clk1, "R9", "mux clk1", ref_out, ref_clk1);
    @(negedge clk); ref_sel = 1'b0;
    wait_cyc(1);
    chk(sel_ind === 1'b0, "R5", "manual sel 0", sel_ind, 0);
    chk(ref_out === ref_clk0, "R9", "mux clk0", ref_out, ref_clk0);

    // R1 stall, R5 no manual switch, R2 latched
    cur_req = "R1";
    @(negedge clk); run0 = 1'b0;
    wait_cyc(8);
    chk(alarm0_n === 1'b1, "R1", "alarm0 before window", alarm0_n, 1);
    wait_cyc(22);
    chk(alarm0_n === 1'b0, "R1", "alarm0 after window", alarm0_n, 0);
    chk(sel_ind === 1'b0, "R5", "manual no switch", sel_ind, 0);
    cur_req = "R2";
    @(negedge clk); run0 = 1'b1;
    wait_cyc(30);
    chk(alarm0_n === 1'b0, "R2", "alarm0 latched", alarm0_n, 0);

    // R3 clear, level hold does not repeat
    cur_req = "R3";
    @(negedge clk); clr = 1'b1;
    wait_cyc(2);
    chk(alarm0_n === 1'b0, "R3", "alarm0 before 3rd edge", alarm0_n, 0);
    wait_cyc(1);
    chk(alarm0_n === 1'b1, "R3", "alarm0 after clear", alarm0_n, 1);
    @(negedge clk); run1 = 1'b0;
    wait_cyc(30);
    chk(alarm1_n === 1'b0, "R3", "held clear does not repeat", alarm1_n, 0);
    @(negedge clk); clr = 1'b0; run1 = 1'b1;
    wait_cyc(10);
    pulse_clr();
    chk(alarm1_n === 1'b1, "R3", "alarm1 cleared", alarm1_n, 1);

    // R4 clear loads select in auto mode
    cur_req = "R4";
    @(negedge clk); auto_mode = 1'b1; ref_sel = 1'b1;
    wait_cyc(3);
    chk(sel_ind === 1'b0, "R6", "auto ignores select", sel_ind, 0);
    pulse_clr();
    chk(sel_ind === 1'b1, "R4", "clear loads select", sel_ind, 1);
    @(negedge clk); ref_sel = 1'b0;
    wait_cyc(3);
    chk(sel_ind === 1'b1, "R6", "auto holds selection", sel_ind, 1);

    // R6 automatic switch
    cur_req = "R6";
    @(negedge clk); run1 = 1'b0;
    wait_cyc(30);
    chk(alarm1_n === 1'b0, "R6", "alarm1 low", alarm1_n, 0);
    chk(sel_ind === 1'b0, "R6", "switched to clk0", sel_ind, 0);
    chk(ref_out === ref_clk0, "R9", "mux after switch", ref_out, ref_clk0);
    @(negedge clk); run1 = 1'b1;
    wait_cyc(20);
    chk(sel_ind === 1'b0, "R6", "no switch back", sel_ind, 0);

    // R7 both failed: hold
    cur_req = "R7";
    @(negedge clk); run0 = 1'b0;
    wait_cyc(30);
    chk(alarm0_n === 1'b0, "R7", "alarm0 low", alarm0_n, 0);
    chk(sel_ind === 1'b0, "R7", "no switch to failed clk1", sel_ind, 0);
    @(negedge clk); run0 = 1'b1;
    wait_cyc(10);
    pulse_clr();
    chk(alarm0_n === 1'b1 && alarm1_n === 1'b1, "R7", "both restored", alarm0_n + alarm1_n, 2);

    // R8 bypass forces manual
    cur_req = "R8";
    @(negedge clk); bypass = 1'b1;
    @(negedge clk); run0 = 1'b0;
    wait_cyc(30);
    chk(alarm0_n === 1'b0, "R8", "alarm0 low in bypass", alarm0_n, 0);
    chk(sel_ind === 1'b0, "R8", "no auto switch in bypass", sel_ind, 0);
    @(negedge clk); ref_sel = 1'b1;
    wait_cyc(1);
    chk(sel_ind === 1'b1, "R8", "bypass follows select", sel_ind, 1);
    @(negedge clk); run0 = 1'b1;

    // R10 lock loss
    cur_req = "R10";
    @(negedge clk); lock = 1'b0;
    wait_cyc(2);
    chk(valid === 1'b0, "R10", "valid drops", valid, 0);
    wait_cyc(5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule